// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a 3-bit synchronous counter that walks a fixed loop of five codes that do not follow binary order: 000, 010, 011, 101, 110, and then 000 again. Each rising clock edge with the count enable high moves it one step along that loop. With the enable low it keeps its present code.

The three codes outside the loop (001, 100 and 111) are not left undefined. The next-state logic sends each of them into the loop within at most two enabled steps. Because of this, the counter recovers from whatever value it holds at power-up, even if the reset is never asserted.

A synchronous clear forces 000. A preload path lets a test environment place any 3-bit code into the register, including the codes outside the loop, so that the recovery paths can be exercised.

Top module: `seqctr_top`

## Requirements
- R1: While clearReq is high at a rising edge, the state becomes 000 at that edge. The clear takes priority over preloadEn and countEn.
- R2: While clearReq is low and preloadEn is high at a rising edge, the state takes the value of preloadVal at that edge. The preload takes priority over countEn.
- R3: While clearReq, preloadEn and countEn are all low at a rising edge, the state keeps its value.
- R4: With only countEn high, the loop codes step in this order: 000 to 010, 010 to 011, 011 to 101, 101 to 110, and 110 back to 000.
- R5: With only countEn high, code 001 steps to 110.
- R6: With only countEn high, code 100 steps to 010.
- R7: With only countEn high, code 111 steps to 100, and then to 010 on the following enabled step.
- R8: Starting from any code, at most two enabled steps bring the state onto the loop. Once the state is on the loop, an enabled step never takes it off the loop.
- R9: The stateOut port shows the register contents directly, with bit 2 as the most significant bit. It therefore changes only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearReq | input | 1 | Synchronous clear to 000 |
| countEn | input | 1 | Advance one step along the sequence |
| preloadEn | input | 1 | Load preloadVal into the state register |
| preloadVal | input | 3 | Code to be loaded, which may be any value |
| stateOut | output | 3 | Current state code, most significant bit first |

## Verification
The assertions take two things for granted. First, clearReq is high from the very first clock edge. Second, every control input holds a defined 0 or 1 value at each rising edge. Under these conditions, $past never refers to the unknown value the register holds at power-up.

The stimulus keeps within these conditions in three ways:
- It raises clearReq at time zero.
- It changes every input only at the falling edge.
- It places codes outside the loop only through the preload path, after the clear.

With this approach, each recovery path starts from a known and deliberate state.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;

  localparam int STATE_W = 3;

  typedef logic [STATE_W-1:0] code_t;

  // Strobes sent from the control module to the datapath.
  // At most one of them is high in any cycle.
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } strobes_t;

  localparam code_t CODE_START = 3'b000;

  // Returns 1 when the code is one of the five codes on the loop.
  function automatic logic isLoopCode(input code_t c);
    case (c)
      3'b000, 3'b010, 3'b011, 3'b101, 3'b110: isLoopCode = 1'b1;
      default:                                isLoopCode = 1'b0;
    endcase
  endfunction

  // Table form of the loop order. The checkers use this to compare
  // against the equation form that the datapath uses.
  function automatic code_t tableSucc(input code_t c);
    case (c)
      3'b000:  tableSucc = 3'b010;
      3'b010:  tableSucc = 3'b011;
      3'b011:  tableSucc = 3'b101;
      3'b101:  tableSucc = 3'b110;
      3'b110:  tableSucc = 3'b000;
      3'b001:  tableSucc = 3'b110;
      3'b100:  tableSucc = 3'b010;
      default: tableSucc = 3'b100;
    endcase
  endfunction

endpackage

// File: rtl/seqctr_ctrl.sv
module seqctr_ctrl
  import seqctr_pkg::*;
(
  input  logic     clk,
  input  logic     clearReq,
  input  logic     preloadEn,
  input  logic     countEn,
  output strobes_t strobes
);

  // Fixed priority: clear first, then preload, then count.
  always_comb begin
    strobes       = '0;
    strobes.clear = clearReq;
    strobes.load  = !clearReq && preloadEn;
    strobes.step  = !clearReq && !preloadEn && countEn;
  end

  // R1 and R2: the priority decode leaves at most one strobe active.
  assert_single_strobe_R1: assert property (@(posedge clk)
    $onehot0({strobes.clear, strobes.load, strobes.step}));

  // R2: a preload request with the clear low always produces a load.
  assert_load_wins_R2: assert property (@(posedge clk) disable iff (clearReq)
    preloadEn |-> strobes.load && !strobes.step);

endmodule

// File: rtl/seqctr_datapath.sv
module seqctr_datapath
  import seqctr_pkg::*;
(
  input  logic     clk,
  input  strobes_t strobes,
  input  code_t    loadVal,
  output code_t    curCode
);

  code_t stateQ;
  code_t nextCode;
  logic  bitA, bitB, bitC;

  assign bitA = stateQ[0];
  assign bitB = stateQ[1];
  assign bitC = stateQ[2];

  // Next-state equations. The free choices for the unused codes are
  // fixed so that each of them leads back onto the loop.
  code_t succCode;
  always_comb begin
    succCode[2] = bitA;
    succCode[1] = !bitB || (!bitA && !bitC);
    succCode[0] = bitB && !bitC;
  end

  always_comb begin
    nextCode = stateQ;
    if (strobes.clear)     nextCode = CODE_START;
    else if (strobes.load) nextCode = loadVal;
    else if (strobes.step) nextCode = succCode;
  end

  always_ff @(posedge clk) begin
    stateQ <= nextCode;
  end

  assign curCode = stateQ;

  assert_clear_zero_R1: assert property (@(posedge clk)
    strobes.clear |=> stateQ == CODE_START);

  assert_load_value_R2: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load |=> stateQ == $past(loadVal));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.load && !strobes.step |=> $stable(stateQ));

  assert_step_order_R4: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.step && isLoopCode(stateQ) |=> stateQ == tableSucc($past(stateQ)));

  assert_escape_001_R5: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.step && stateQ == 3'b001 |=> stateQ == 3'b110);

  assert_escape_100_R6: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.step && stateQ == 3'b100 |=> stateQ == 3'b010);

  assert_escape_111_R7: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.step && stateQ == 3'b111 |=> stateQ == 3'b100);

  assert_stay_on_loop_R8: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.step && isLoopCode(stateQ) |=> isLoopCode(stateQ));

endmodule

// File: rtl/seqctr_top.sv
module seqctr_top
  import seqctr_pkg::*;
(
  input  logic               clk,
  input  logic               clearReq,
  input  logic               countEn,
  input  logic               preloadEn,
  input  logic [STATE_W-1:0] preloadVal,
  output logic [STATE_W-1:0] stateOut
);

  strobes_t strobes;
  code_t    curCode;

  seqctr_ctrl ctrl_i (
    .clk       (clk),
    .clearReq  (clearReq),
    .preloadEn (preloadEn),
    .countEn   (countEn),
    .strobes   (strobes)
  );

  seqctr_datapath dp_i (
    .clk     (clk),
    .strobes (strobes),
    .loadVal (preloadVal),
    .curCode (curCode)
  );

  assign stateOut = curCode;

  // R9: the output changes only at a rising edge. It is sampled
  // here against its value at the previous edge.
  assert_output_is_state_R9: assert property (@(posedge clk) disable iff (clearReq)
    !countEn && !preloadEn |=> stateOut == $past(stateOut));

endmodule

// File: tb/seqctr_top_tb_top.sv
module seqctr_top_tb_top;

  logic       clk = 1'b0;
  logic       clearReq = 1'b1;
  logic       countEn = 1'b0;
  logic       preloadEn = 1'b0;
  logic [2:0] preloadVal = 3'b000;
  logic [2:0] stateOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  seqctr_top dut_i (
    .clk        (clk),
    .clearReq   (clearReq),
    .countEn    (countEn),
    .preloadEn  (preloadEn),
    .preloadVal (preloadVal),
    .stateOut   (stateOut)
  );

  // Model of the loop order, built from the position of each code on
  // the loop.
  function automatic int loopPos(input logic [2:0] c);
    case (c)
      3'b000:  loopPos = 0;
      3'b010:  loopPos = 1;
      3'b011:  loopPos = 2;
      3'b101:  loopPos = 3;
      3'b110:  loopPos = 4;
      default: loopPos = -1;
    endcase
  endfunction

  function automatic logic [2:0] posCode(input int p);
    logic [2:0] seq [5] = '{3'b000, 3'b010, 3'b011, 3'b101, 3'b110};
    posCode = seq[p % 5];
  endfunction

  function automatic logic [2:0] expSucc(input logic [2:0] c);
    if (loopPos(c) >= 0)    expSucc = posCode(loopPos(c) + 1);
    else if (c == 3'b001)   expSucc = 3'b110;
    else if (c == 3'b100)   expSucc = 3'b010;
    else                    expSucc = 3'b100;
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (stateOut !== exp) begin
      fails++;
      $display("FAIL %s: stateOut=%b expected=%b", req, stateOut, exp);
    end
  endtask

  // Drive the inputs at the falling edge, let one rising edge pass,
  // then sample at the next falling edge.
  task automatic cycle(input logic clr, input logic ld,
                       input logic en, input logic [2:0] v);
    clearReq   = clr;
    preloadEn  = ld;
    countEn    = en;
    preloadVal = v;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: stateOut=%b expected=finish", stateOut);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cycle(1, 0, 0, 3'b000);
    check("R1 reset", 3'b000);

    // R4: full loop walked twice.
    for (int i = 1; i <= 10; i++) begin
      cycle(0, 0, 1, 3'b000);
      check("R4 loop", posCode(i));
      check("R9 output", posCode(i));
    end

    // Sweep over every code: preload it, hold it, take one step,
    // then take a second step.
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code = 3'(c);
      cycle(0, 1, 0, code);
      check("R2 preload", code);
      cycle(0, 0, 0, 3'(~c));
      check("R3 hold", code);
      cycle(0, 0, 1, 3'b000);
      if (code == 3'b001)      check("R5 escape", expSucc(code));
      else if (code == 3'b100) check("R6 escape", expSucc(code));
      else if (code == 3'b111) check("R7 escape", expSucc(code));
      else                     check("R4 step", expSucc(code));
      cycle(0, 0, 1, 3'b000);
      check("R8 onloop", expSucc(expSucc(code)));
      checks++;
      if (loopPos(stateOut) < 0) begin
        fails++;
        $display("FAIL R8: stateOut=%b expected=loop code", stateOut);
      end
    end

    // R7: 111 reaches 010 in two enabled steps.
    cycle(0, 1, 0, 3'b111);
    cycle(0, 0, 1, 3'b000);
    cycle(0, 0, 1, 3'b000);
    check("R7 two steps", 3'b010);

    // R2: a preload takes priority over the count enable.
    cycle(0, 1, 1, 3'b100);
    check("R2 over enable", 3'b100);

    // R1: a clear takes priority over preload and count enable.
    cycle(1, 1, 1, 3'b111);
    check("R1 over load", 3'b000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule